// File: doc/BRIEF.md
# Multimode Counter and Shift Register

This block is a small state register, four bits wide by default, that does one of eight operations on every rising clock edge. A 3-bit operation select picks the operation: parallel load, bitwise inversion, a shift in either direction, a count up or down (modulo 2^W), a synchronous clear, or hold. An active-high master reset clears the state at once and does not wait for the clock.

One input does two jobs. It is the serial bit that enters the least significant end when the register shifts toward the MSB. It is also the active-low trickle enable for counting. A separate input gives the serial bit that enters the most significant end when the register shifts toward the LSB. The terminal output is combinational, and its meaning depends on the operation. In the count modes it is an active-low carry or borrow. In the shift modes it repeats the most significant state bit. In every other mode it is a constant. Because of this, one wire from the terminal output of one stage to the shared input of the next stage chains several stages into a wider counter or a wider shift-up register.

The outputs are the state and its bitwise complement.

Top module: `mm_cntshift`

## Requirements
- R1: While `mrst` is high, the state reads zero at once, without waiting for a clock edge. Clock edges during reset are ignored in every mode. The terminal output keeps following the mode rules, applied to a zero state.
- R2: With `mode_sel` = 3'b000 (load), the state takes `preset` at the edge and `term_out` is 0.
- R3: With `mode_sel` = 3'b001 (invert), every state bit flips at the edge and `term_out` is 0.
- R4: With `mode_sel` = 3'b010 (shift toward LSB), bit i takes the old bit i+1 and the top bit takes `ser_hi`. `term_out` equals the top state bit.
- R5: With `mode_sel` = 3'b011 (shift toward MSB), bit i takes the old bit i-1 and bit 0 takes `ser_trk_n`. `term_out` equals the top state bit.
- R6: With `mode_sel` = 3'b110 (up) or 3'b100 (down), the state steps by one modulo 2^W, with bit 0 as the LSB. It steps only when `cnt_en_n` and `ser_trk_n` are both 0. Otherwise it holds.
- R7: In up mode, `term_out` is 0 exactly when the state is all ones and `ser_trk_n` is 0. In down mode, `term_out` is 0 exactly when the state is zero and `ser_trk_n` is 0. In both modes, `term_out` is 1 whenever `ser_trk_n` is 1, whatever `cnt_en_n` is.
- R8: With `mode_sel` = 3'b101 (clear), the state becomes zero at the edge. With `mode_sel` = 3'b111 (hold), the state keeps its value and every data input is ignored. In both modes `term_out` is 1.
- R9: `q_n` is always the bitwise inverse of `q`.
- R10: Three stages can be chained by wiring each stage's `term_out` to the next stage's `ser_trk_n`. Such a chain counts up and down as one 12-bit counter, wrapping around at both ends. It also shifts toward the MSB as one 12-bit register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| mrst | input | 1 | Master reset, active high, asynchronous |
| mode_sel | input | 3 | Operation select |
| preset | input | W | Parallel load value |
| cnt_en_n | input | 1 | Parallel count enable, active low |
| ser_trk_n | input | 1 | Serial bit for shifting toward the MSB, and trickle count enable (active low) |
| ser_hi | input | 1 | Serial bit for shifting toward the LSB |
| q | output | W | State |
| q_n | output | W | Complement of the state |
| term_out | output | 1 | Terminal output; its meaning depends on the mode |

## Verification
Two functions can act at the same moment. The asynchronous master reset can rise in the middle of a clock period, while a load or a count is selected. Clock edges can also arrive while the reset is still held. The bench raises `mrst` a few nanoseconds after a rising edge and checks `q`, `q_n` and `term_out` before the next edge. It then changes the mode while the reset is held and checks that the terminal output follows the zero state. Finally it lets a load edge pass under reset and checks that the state stays at zero.

// File: rtl/mmcs_pkg.sv
package mmcs_pkg;
   typedef enum logic [2:0] {
      OP_LOAD     = 3'b000,
      OP_INV      = 3'b001,
      OP_SHIFT_LO = 3'b010,
      OP_SHIFT_HI = 3'b011,
      OP_DOWN     = 3'b100,
      OP_CLR      = 3'b101,
      OP_UP       = 3'b110,
      OP_HOLD     = 3'b111
   } op_e;
endpackage

// File: rtl/mmcs_step.sv
// Increment/decrement unit; STEP_STYLE picks an adder (0) or a toggle chain (1).
module mmcs_step #(
   parameter int W          = 4,
   parameter int STEP_STYLE = 0
) (
   input  logic [W-1:0] cur,
   input  logic         dir_up,
   output logic [W-1:0] nxt
);
   localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

   if (STEP_STYLE != 0 && STEP_STYLE != 1) begin : g_bad_style
      $error("mmcs_step: STEP_STYLE must be 0 or 1");
   end

   if (STEP_STYLE == 0) begin : g_adder
      assign nxt = dir_up ? (cur + ONE) : (cur - ONE);
   end else begin : g_toggle
      always_comb begin
         logic run_one;
         logic run_zero;
         run_one  = 1'b1;
         run_zero = 1'b1;
         for (int i = 0; i < W; i++) begin
            nxt[i]   = cur[i] ^ (dir_up ? run_one : run_zero);
            run_one  = run_one & cur[i];
            run_zero = run_zero & ~cur[i];
         end
      end
   end
endmodule

// File: rtl/mmcs_next.sv
// Next-state selection for all eight operations.
module mmcs_next
   import mmcs_pkg::*;
#(
   parameter int W          = 4,
   parameter int STEP_STYLE = 0
) (
   input  op_e          op,
   input  logic [W-1:0] cur,
   input  logic [W-1:0] preset,
   input  logic         cep_n,
   input  logic         trk_n,
   input  logic         ser_hi,
   output logic [W-1:0] nxt
);
   logic [W-1:0] to_lo;
   logic [W-1:0] to_hi;
   logic [W-1:0] stepped;
   logic         step_ok;

   for (genvar i = 0; i < W; i++) begin : g_shift
      if (i == W - 1) begin : g_top
         assign to_lo[i] = ser_hi;
      end else begin : g_mid_lo
         assign to_lo[i] = cur[i+1];
      end
      if (i == 0) begin : g_bot
         assign to_hi[i] = trk_n;
      end else begin : g_mid_hi
         assign to_hi[i] = cur[i-1];
      end
   end

   mmcs_step #(.W(W), .STEP_STYLE(STEP_STYLE)) u_step (
      .cur    (cur),
      .dir_up (op == OP_UP),
      .nxt    (stepped)
   );

   assign step_ok = ~cep_n & ~trk_n;

   always_comb begin
      case (op)
         OP_LOAD:     nxt = preset;
         OP_INV:      nxt = ~cur;
         OP_SHIFT_LO: nxt = to_lo;
         OP_SHIFT_HI: nxt = to_hi;
         OP_DOWN,
         OP_UP:       nxt = step_ok ? stepped : cur;
         OP_CLR:      nxt = '0;
         default:     nxt = cur;
      endcase
   end
endmodule

// File: rtl/mmcs_term.sv
// Mode-dependent terminal output (combinational).
module mmcs_term
   import mmcs_pkg::*;
#(
   parameter int W = 4
) (
   input  op_e          op,
   input  logic [W-1:0] cur,
   input  logic         trk_n,
   output logic         term
);
   logic at_max;
   logic at_min;

   assign at_max = &cur;
   assign at_min = ~|cur;

   always_comb begin
      case (op)
         OP_LOAD,
         OP_INV:      term = 1'b0;
         OP_SHIFT_LO,
         OP_SHIFT_HI: term = cur[W-1];
         OP_UP:       term = ~(at_max & ~trk_n);
         OP_DOWN:     term = ~(at_min & ~trk_n);
         default:     term = 1'b1;
      endcase
   end
endmodule

// File: rtl/mm_cntshift.sv
module mm_cntshift
   import mmcs_pkg::*;
#(
   parameter int W          = 4,
   parameter int STEP_STYLE = 0
) (
   input  logic         clk,
   input  logic         mrst,
   input  logic [2:0]   mode_sel,
   input  logic [W-1:0] preset,
   input  logic         cnt_en_n,
   input  logic         ser_trk_n,
   input  logic         ser_hi,
   output logic [W-1:0] q,
   output logic [W-1:0] q_n,
   output logic         term_out
);
   if (W < 2) begin : g_bad_width
      $error("mm_cntshift: W must be at least 2");
   end

   op_e          op;
   logic [W-1:0] state;
   logic [W-1:0] nxt;

   assign op = op_e'(mode_sel);

   mmcs_next #(.W(W), .STEP_STYLE(STEP_STYLE)) u_next (
      .op     (op),
      .cur    (state),
      .preset (preset),
      .cep_n  (cnt_en_n),
      .trk_n  (ser_trk_n),
      .ser_hi (ser_hi),
      .nxt    (nxt)
   );

   mmcs_term #(.W(W)) u_term (
      .op    (op),
      .cur   (state),
      .trk_n (ser_trk_n),
      .term  (term_out)
   );

   always_ff @(posedge clk or posedge mrst) begin
      if (mrst) state <= '0;
      else      state <= nxt;
   end

   assign q   = state;
   assign q_n = ~state;

   // R3
   invert_flip_chk: assert property (@(posedge clk) disable iff (mrst)
      (op == OP_INV) |=> (state == ~$past(state)));

   // R4
   shift_lo_entry_chk: assert property (@(posedge clk) disable iff (mrst)
      (op == OP_SHIFT_LO) |=> (state[W-1] == $past(ser_hi)));

   // R5
   shift_hi_entry_chk: assert property (@(posedge clk) disable iff (mrst)
      (op == OP_SHIFT_HI) |=> (state[0] == $past(ser_trk_n)));

   // R6
   count_gate_chk: assert property (@(posedge clk) disable iff (mrst)
      ((op == OP_UP || op == OP_DOWN) && (cnt_en_n || ser_trk_n)) |=> (state == $past(state)));

   // R7
   up_wrap_chk: assert property (@(posedge clk) disable iff (mrst)
      (op == OP_UP && !cnt_en_n && !term_out) |=> (state == '0));

   // R8
   clear_zero_chk: assert property (@(posedge clk) disable iff (mrst)
      (op == OP_CLR) |=> (state == '0));
endmodule

// File: tb/mm_cntshift_test.sv
module mm_cntshift_test;
   logic       clk = 1'b0;
   logic       mrst = 1'b1;
   logic [2:0] mode_sel = 3'b111;
   logic [3:0] preset = 4'h0;
   logic       cnt_en_n = 1'b0;
   logic       ser_trk_n = 1'b0;
   logic       ser_hi = 1'b0;
   logic [3:0] q, q_n;
   logic       term_out;

   int compared = 0;
   int mismatched = 0;
   int cycles = 0;

   always #10 clk = ~clk;

   mm_cntshift #(.W(4)) uut (
      .clk(clk), .mrst(mrst), .mode_sel(mode_sel), .preset(preset),
      .cnt_en_n(cnt_en_n), .ser_trk_n(ser_trk_n), .ser_hi(ser_hi),
      .q(q), .q_n(q_n), .term_out(term_out)
   );

   // three-stage chain
   logic        c_rst = 1'b1;
   logic [2:0]  c_mode = 3'b111;
   logic [11:0] c_pre = 12'h000;
   logic        c_cep = 1'b0;
   logic        c_ext = 1'b0;
   logic [11:0] c_q, c_qn;
   logic [2:0]  c_tc;

   for (genvar s = 0; s < 3; s++) begin : g_chain
      logic trk_in;
      if (s == 0) begin : g_first
         assign trk_in = c_ext;
      end else begin : g_next
         assign trk_in = c_tc[s-1];
      end
      mm_cntshift #(.W(4), .STEP_STYLE(s % 2)) stage (
         .clk(clk), .mrst(c_rst), .mode_sel(c_mode), .preset(c_pre[4*s +: 4]),
         .cnt_en_n(c_cep), .ser_trk_n(trk_in), .ser_hi(1'b0),
         .q(c_q[4*s +: 4]), .q_n(c_qn[4*s +: 4]), .term_out(c_tc[s])
      );
   end

   // {mode, preset, cnt_en_n, ser_trk_n, ser_hi, expected q, expected term_out}
   localparam int NV = 26;
   localparam logic [14:0] VEC [0:NV-1] = '{
      {3'd0, 4'hA, 1'b0, 1'b0, 1'b0, 4'hA, 1'b0},  // R2 load
      {3'd1, 4'h0, 1'b0, 1'b0, 1'b0, 4'h5, 1'b0},  // R3 invert
      {3'd2, 4'h0, 1'b0, 1'b0, 1'b1, 4'hA, 1'b1},  // R4 shift toward LSB
      {3'd2, 4'h0, 1'b0, 1'b0, 1'b0, 4'h5, 1'b0},  // R4
      {3'd3, 4'h0, 1'b0, 1'b1, 1'b0, 4'hB, 1'b1},  // R5 shift toward MSB
      {3'd3, 4'h0, 1'b0, 1'b0, 1'b0, 4'h6, 1'b0},  // R5
      {3'd6, 4'h0, 1'b0, 1'b0, 1'b0, 4'h7, 1'b1},  // R6 up
      {3'd0, 4'hE, 1'b0, 1'b0, 1'b0, 4'hE, 1'b0},  // R2
      {3'd6, 4'h0, 1'b0, 1'b0, 1'b0, 4'hF, 1'b0},  // R7 up at all ones
      {3'd6, 4'h0, 1'b0, 1'b0, 1'b0, 4'h0, 1'b1},  // R6 wrap
      {3'd6, 4'h0, 1'b1, 1'b0, 1'b0, 4'h0, 1'b1},  // R6 parallel enable off
      {3'd4, 4'h0, 1'b0, 1'b0, 1'b0, 4'hF, 1'b1},  // R6 down wrap
      {3'd4, 4'h0, 1'b0, 1'b1, 1'b0, 4'hF, 1'b1},  // R6 trickle off
      {3'd0, 4'h1, 1'b0, 1'b0, 1'b0, 4'h1, 1'b0},  // R2
      {3'd4, 4'h0, 1'b0, 1'b0, 1'b0, 4'h0, 1'b0},  // R7 down at zero
      {3'd4, 4'h0, 1'b1, 1'b0, 1'b0, 4'h0, 1'b0},  // R7 parallel enable ignored
      {3'd4, 4'h0, 1'b1, 1'b1, 1'b0, 4'h0, 1'b1},  // R7 trickle high
      {3'd0, 4'h9, 1'b0, 1'b0, 1'b0, 4'h9, 1'b0},  // R2
      {3'd5, 4'h0, 1'b0, 1'b0, 1'b0, 4'h0, 1'b1},  // R8 clear
      {3'd0, 4'hC, 1'b0, 1'b0, 1'b0, 4'hC, 1'b0},  // R2
      {3'd7, 4'h0, 1'b0, 1'b0, 1'b0, 4'hC, 1'b1},  // R8 hold
      {3'd7, 4'h3, 1'b0, 1'b0, 1'b1, 4'hC, 1'b1},  // R8 hold ignores inputs
      {3'd6, 4'h0, 1'b0, 1'b1, 1'b0, 4'hC, 1'b1},  // R6 up trickle off
      {3'd4, 4'h0, 1'b0, 1'b0, 1'b0, 4'hB, 1'b1},  // R6 down
      {3'd0, 4'hF, 1'b0, 1'b0, 1'b0, 4'hF, 1'b0},  // R2
      {3'd6, 4'h0, 1'b0, 1'b1, 1'b0, 4'hF, 1'b1}   // R7 all ones, trickle high
   };

   task automatic chk(input string tag, input logic [11:0] act, input logic [11:0] exp);
      compared++;
      if (act !== exp) begin
         mismatched++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 150000) begin
         mismatched++;
         compared++;
         $display("FAIL watchdog: actual %0d expected <150000 cycles", cycles);
         finish_run();
      end
   end

   initial begin
      logic [11:0] ref_v;
      logic        bit_in;
      // R1 reset state
      @(negedge clk);
      chk("R1 reset q", {8'h0, q}, 12'h000);
      chk("R9 reset q_n", {8'h0, q_n}, 12'h00F);
      chk("R8 hold term during reset", {11'h0, term_out}, 12'h001);
      mrst = 1'b0;

      for (int i = 0; i < NV; i++) begin
         mode_sel  = VEC[i][14:12];
         preset    = VEC[i][11:8];
         cnt_en_n  = VEC[i][7];
         ser_trk_n = VEC[i][6];
         ser_hi    = VEC[i][5];
         @(negedge clk);
         chk($sformatf("vec %0d q (R2-8 table)", i), {8'h0, q}, {8'h0, VEC[i][4:1]});
         chk($sformatf("vec %0d term_out (R7 table)", i), {11'h0, term_out}, {11'h0, VEC[i][0]});
         chk($sformatf("vec %0d R9 q_n", i), {8'h0, q_n}, {8'h0, ~VEC[i][4:1]});
      end

      // R1 mid-cycle asynchronous reset
      mode_sel = 3'd0; preset = 4'h7; cnt_en_n = 1'b0; ser_trk_n = 1'b0;
      @(negedge clk);
      chk("R2 load before reset", {8'h0, q}, 12'h007);
      @(posedge clk);
      #4 mrst = 1'b1;
      #1;
      chk("R1 async clear q", {8'h0, q}, 12'h000);
      chk("R9 q_n under reset", {8'h0, q_n}, 12'h00F);
      chk("R1 load term under reset", {11'h0, term_out}, 12'h000);
      mode_sel = 3'd4;
      #1 chk("R1 down term under reset", {11'h0, term_out}, 12'h000);
      mode_sel = 3'd6;
      #1 chk("R1 up term under reset", {11'h0, term_out}, 12'h001);
      mode_sel = 3'd0; preset = 4'hA;
      @(negedge clk);
      @(negedge clk);
      chk("R1 edge ignored under reset", {8'h0, q}, 12'h000);
      mrst = 1'b0;
      @(negedge clk);
      chk("R2 load after release", {8'h0, q}, 12'h00A);

      // R10 chained 12-bit counter
      @(negedge clk);
      c_rst = 1'b0;
      c_mode = 3'd6; c_cep = 1'b0; c_ext = 1'b0;
      ref_v = 12'h000;
      for (int k = 0; k < 40; k++) begin
         @(negedge clk);
         ref_v = ref_v + 12'h001;
         chk("R10 chain up", c_q, ref_v);
      end
      c_mode = 3'd0; c_pre = 12'hFF8;
      @(negedge clk);
      ref_v = 12'hFF8;
      chk("R10 chain load", c_q, ref_v);
      c_mode = 3'd6;
      for (int k = 0; k < 20; k++) begin
         @(negedge clk);
         ref_v = ref_v + 12'h001;
         chk("R10 chain up through wrap", c_q, ref_v);
         chk("R10 chain q_n", c_qn, ~ref_v);
      end
      c_ext = 1'b1;
      for (int k = 0; k < 3; k++) begin
         @(negedge clk);
         chk("R10 chain held by trickle", c_q, ref_v);
      end
      c_ext = 1'b0;
      c_mode = 3'd0; c_pre = 12'h105;
      @(negedge clk);
      ref_v = 12'h105;
      c_mode = 3'd4;
      for (int k = 0; k < 270; k++) begin
         @(negedge clk);
         ref_v = ref_v - 12'h001;
         chk("R10 chain down through wrap", c_q, ref_v);
      end

      // R10 chained 12-bit shift toward MSB
      c_rst = 1'b1;
      @(negedge clk);
      c_rst = 1'b0;
      c_mode = 3'd3;
      ref_v = 12'h000;
      for (int k = 0; k < 30; k++) begin
         bit_in = ((k * 7 + 3) % 5) < 2;
         c_ext = bit_in;
         @(negedge clk);
         ref_v = {ref_v[10:0], bit_in};
         chk("R10 chain shift", c_q, ref_v);
         chk("R10 chain shift top term", {11'h0, c_tc[2]}, {11'h0, ref_v[11]});
      end

      finish_run();
   end
endmodule